// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address-Marker Bit

This block is the receive half of an asynchronous serial port. It watches one serial line and counts periods of an oversampling tick (`sampleEn`). From those ticks it rebuilds 8-bit characters, sent least significant bit first. Each character may carry an optional parity bit and an optional marker bit. The marker bit tells an address character apart from a data character. It is carried between the data (or parity) bit and the stop bit.

Each received character is checked for parity and framing faults. A completed character is loaded into a single holding register, and the block pulses `rxStrobe`. The holding register stays full until the consumer pulses `readAck`. A character that completes while the register is still full is dropped and flagged as an overrun. A line held low through a whole frame is reported as a break and does not produce a character.

The number of ticks per bit is chosen at run time as 1, 16, 32 or 64. With the three oversampled ratios the start bit is confirmed at its centre, and a shorter low pulse is rejected. With a ratio of 1 each tick takes one bit and there is no centre check.

Top module: `serial_mp_rx`

## Requirements
- R1: After reset, `rxFull`, `rxStrobe`, `rxBreak`, `rxOverrun`, `rxParErr`, `rxFrameErr` and `rxMp` are all 0.
- R2: `cfgRatio` selects the ticks per bit: 0 gives 1, 1 gives 16, 2 gives 32 and 3 gives 64. The receiver advances only on cycles where `sampleEn` is 1. Data bits arrive least significant bit first after one low start bit.
- R3: For ratios 16, 32 and 64, a start bit is accepted only if the line is still low half a bit period after the falling edge was seen. Otherwise the receiver returns to hunting and delivers nothing.
- R4: For ratio 1, the first low tick is taken as the start bit, and each following tick supplies the next bit.
- R5: When `cfgParityEn` is 1, a parity bit follows the 8 data bits. With `cfgParityOdd` 0 the data and parity ones must total an even count; with 1 they must total an odd count. A mismatch sets `rxParErr` for that character. With parity off, `rxParErr` is 0.
- R6: When `cfgMpEn` is 1, a marker bit follows the data bits (and the parity bit when present) and comes before the stop bit. It is reported on `rxMp`. With the marker off, `rxMp` is 0.
- R7: A character whose stop bit is sampled low, and that is not a break, is still delivered, with `rxFrameErr` set to 1.
- R8: When every data, parity, marker and stop position of a frame is 0, `rxBreak` pulses for one cycle and no character is delivered. The receiver then waits for the line to return high before it looks for a new start bit.
- R9: A character that completes while `rxFull` is 1 and `readAck` is 0 is discarded. `rxOverrun` becomes 1 and the held character stays unchanged.
- R10: A `readAck` pulse while `rxFull` is 1 clears `rxFull` and `rxOverrun`.
- R11: `rxStrobe` is a one-cycle pulse in the cycle the holding register is loaded. The data and flag outputs are valid from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleEn | input | 1 | Oversampling tick enable |
| rxLine | input | 1 | Serial input line, idle high |
| cfgRatio | input | 2 | Ticks per bit: 0=1, 1=16, 2=32, 3=64 |
| cfgParityEn | input | 1 | Parity bit present |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| cfgMpEn | input | 1 | Marker bit present |
| readAck | input | 1 | Consumer has taken the held character |
| rxData | output | 8 | Held character |
| rxMp | output | 1 | Held marker bit |
| rxParErr | output | 1 | Held character failed parity |
| rxFrameErr | output | 1 | Held character had a low stop bit |
| rxOverrun | output | 1 | A later character was lost |
| rxFull | output | 1 | Holding register occupied |
| rxStrobe | output | 1 | One-cycle pulse on load |
| rxBreak | output | 1 | One-cycle pulse on break detection |

## Verification
The bench sends a low pulse shorter than half a bit. A receiver without the centre check would decode a bogus 0xFF-like character, and the scoreboard would see an unexpected strobe. An all-zero frame must give a break with no character: a design that treated it as a framing error would deliver 0x00. A design that did not wait for the line to go high would find a false start bit. The overrun case holds off the read while a second frame arrives. A design that overwrote the holding register would show the second byte instead of the first. Marker and parity frames use bit patterns that shift every later field if a field is put in the wrong position. Frames are also sent at each ratio and with a sparse tick, so a period computed in clock cycles rather than ticks gives wrong bytes.

// File: rtl/serial_mp_rx_pkg.sv
package serial_mp_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_CONFIRM,
    ST_FIELDS,
    ST_WAIT_HIGH
  } rxState_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic startFrame;
    logic capData;
    logic capPar;
    logic capMp;
    logic capStop;
    logic bitVal;
    logic parOn;
    logic parOdd;
    logic mpOn;
  } rxStrobe_t;

  function automatic logic [6:0] ticksPerBit(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7'd1;
      2'd1:    return 7'd16;
      2'd2:    return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

endpackage

// File: rtl/serial_mp_rx_ctrl.sv
module serial_mp_rx_ctrl
  import serial_mp_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       rxLine,
  input  logic [1:0] cfgRatio,
  input  logic       cfgParityEn,
  input  logic       cfgParityOdd,
  input  logic       cfgMpEn,
  output rxStrobe_t  stb
);
  localparam int IDX_W = $clog2(DATA_W + 3);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineS;
  rxState_e               state;
  logic [CNT_W-1:0]       cnt;
  logic [IDX_W-1:0]       bitIdx;
  logic [1:0]             ratioL;
  logic                   parOnL, parOddL, mpOnL;
  logic [IDX_W-1:0]       lastIdx;
  logic [6:0]             ticksL, ticksNow;
  logic [CNT_W-1:0]       periodM1, halfM1;
  logic                   detect, confirmTick, sampleNow;
  logic                   isData, isPar, isStop;

  // metastability guard on the asynchronous line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign lineS = syncQ[SYNC_STAGES-1];

  assign ticksL   = ticksPerBit(ratioL);
  assign ticksNow = ticksPerBit(cfgRatio);
  assign periodM1 = CNT_W'(ticksL - 7'd1);
  assign halfM1   = CNT_W'((ticksNow >> 1) - 7'd1);
  assign lastIdx  = IDX_W'(DATA_W) + IDX_W'(parOnL) + IDX_W'(mpOnL);

  assign detect      = (state == ST_HUNT) && sampleEn && !lineS;
  assign confirmTick = (state == ST_CONFIRM) && sampleEn && (cnt == '0);
  assign sampleNow   = (state == ST_FIELDS) && sampleEn && (cnt == '0);

  assign isData = (bitIdx < IDX_W'(DATA_W));
  assign isStop = (bitIdx == lastIdx);
  assign isPar  = !isData && !isStop && parOnL && (bitIdx == IDX_W'(DATA_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      cnt     <= '0;
      bitIdx  <= '0;
      ratioL  <= '0;
      parOnL  <= 1'b0;
      parOddL <= 1'b0;
      mpOnL   <= 1'b0;
    end else if (sampleEn) begin
      unique case (state)
        ST_HUNT: begin
          if (!lineS) begin
            ratioL  <= cfgRatio;
            parOnL  <= cfgParityEn;
            parOddL <= cfgParityOdd;
            mpOnL   <= cfgMpEn;
            bitIdx  <= '0;
            if (cfgRatio == 2'd0) begin
              state <= ST_FIELDS;
              cnt   <= '0;
            end else begin
              state <= ST_CONFIRM;
              cnt   <= halfM1;
            end
          end
        end
        ST_CONFIRM: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (lineS) begin
            state <= ST_HUNT;
          end else begin
            state <= ST_FIELDS;
            cnt   <= periodM1;
          end
        end
        ST_FIELDS: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cnt <= periodM1;
            if (isStop) state <= lineS ? ST_HUNT : ST_WAIT_HIGH;
            else        bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_WAIT_HIGH: begin
          if (lineS) state <= ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    stb            = '0;
    stb.startFrame = detect;
    stb.capData    = sampleNow && isData;
    stb.capPar     = sampleNow && isPar;
    stb.capStop    = sampleNow && isStop;
    stb.capMp      = sampleNow && !isData && !isStop && !isPar;
    stb.bitVal     = lineS;
    stb.parOn      = parOnL;
    stb.parOdd     = parOddL;
    stb.mpOn       = mpOnL;
  end

  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(state) && $stable(cnt)) else $error("state moved without tick"); // R2

  AST_ONE_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capData, stb.capPar, stb.capMp, stb.capStop})) else $error("field overlap"); // R6

  AST_CONFIRM_HALF_RATIO: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONFIRM) |-> (ratioL != 2'd0)) else $error("confirm at ratio 1"); // R4

endmodule

// File: rtl/serial_mp_rx_dp.sv
module serial_mp_rx_dp
  import serial_mp_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic              readAck,
  output logic [DATA_W-1:0] rxData,
  output logic              rxMp,
  output logic              rxParErr,
  output logic              rxFrameErr,
  output logic              rxOverrun,
  output logic              rxFull,
  output logic              rxStrobe,
  output logic              rxBreak
);
  logic [DATA_W-1:0] shiftQ;
  logic              parQ, mpQ, anyOne;
  logic              isBreak, loadNow, dropNow;
  logic              parBad;

  // frame assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
      mpQ    <= 1'b0;
      anyOne <= 1'b0;
    end else if (stb.startFrame) begin
      parQ   <= 1'b0;
      mpQ    <= 1'b0;
      anyOne <= 1'b0;
    end else begin
      if (stb.capData) shiftQ <= {stb.bitVal, shiftQ[DATA_W-1:1]};
      if (stb.capPar)  parQ   <= stb.bitVal;
      if (stb.capMp)   mpQ    <= stb.bitVal;
      if (stb.capData || stb.capPar || stb.capMp) anyOne <= anyOne | stb.bitVal;
    end
  end

  assign isBreak = stb.capStop && !anyOne && !stb.bitVal;
  assign loadNow = stb.capStop && !isBreak && (!rxFull || readAck);
  assign dropNow = stb.capStop && !isBreak && rxFull && !readAck;
  assign parBad  = stb.parOn && ((^{shiftQ, parQ}) != stb.parOdd);

  // single-entry holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxMp       <= 1'b0;
      rxParErr   <= 1'b0;
      rxFrameErr <= 1'b0;
      rxOverrun  <= 1'b0;
      rxFull     <= 1'b0;
      rxStrobe   <= 1'b0;
      rxBreak    <= 1'b0;
    end else begin
      rxStrobe <= loadNow;
      rxBreak  <= isBreak;
      if (loadNow) begin
        rxData     <= shiftQ;
        rxMp       <= stb.mpOn & mpQ;
        rxParErr   <= parBad;
        rxFrameErr <= !stb.bitVal;
        rxOverrun  <= 1'b0;
        rxFull     <= 1'b1;
      end else if (dropNow) begin
        rxOverrun  <= 1'b1;
      end else if (readAck) begin
        rxFull     <= 1'b0;
        rxOverrun  <= 1'b0;
      end
    end
  end

  AST_BREAK_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    rxBreak |-> !rxStrobe) else $error("break delivered a char"); // R8

  AST_OVR_KEEPS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $stable(rxData) && rxFull) else $error("held data lost"); // R9

  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (readAck && rxFull) |=> (!rxFull || rxStrobe)) else $error("ack ignored"); // R10

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> !rxStrobe) else $error("strobe too long"); // R11

  AST_STROBE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |-> rxFull && !rxOverrun) else $error("strobe without load"); // R11

endmodule

// File: rtl/serial_mp_rx.sv
module serial_mp_rx
  import serial_mp_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              rxLine,
  input  logic [1:0]        cfgRatio,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgMpEn,
  input  logic              readAck,
  output logic [DATA_W-1:0] rxData,
  output logic              rxMp,
  output logic              rxParErr,
  output logic              rxFrameErr,
  output logic              rxOverrun,
  output logic              rxFull,
  output logic              rxStrobe,
  output logic              rxBreak
);
  rxStrobe_t stb;

  serial_mp_rx_ctrl #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxLine(rxLine),
    .cfgRatio(cfgRatio), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgMpEn(cfgMpEn), .stb(stb)
  );

  serial_mp_rx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .readAck(readAck),
    .rxData(rxData), .rxMp(rxMp), .rxParErr(rxParErr),
    .rxFrameErr(rxFrameErr), .rxOverrun(rxOverrun), .rxFull(rxFull),
    .rxStrobe(rxStrobe), .rxBreak(rxBreak)
  );

endmodule

// File: tb/serial_mp_rx_bench.sv
module serial_mp_rx_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleEn = 1'b1;
  logic       rxLine = 1'b1;
  logic [1:0] cfgRatio = 2'd1;
  logic       cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgMpEn = 1'b0;
  logic       readAck = 1'b0;
  logic [7:0] rxData;
  logic       rxMp, rxParErr, rxFrameErr, rxOverrun, rxFull, rxStrobe, rxBreak;

  int checks = 0, failures = 0;
  int tickGap = 1, gapCnt = 0;
  int breakSeen = 0;
  bit autoRead = 1'b1, manualAck = 1'b0, prevStrobe = 1'b0;
  logic [10:0] expQ[$];   // {data, mp, parErr, frameErr}

  always #10 clk = ~clk;

  serial_mp_rx u_serial_mp_rx (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxLine(rxLine),
    .cfgRatio(cfgRatio), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgMpEn(cfgMpEn), .readAck(readAck), .rxData(rxData), .rxMp(rxMp),
    .rxParErr(rxParErr), .rxFrameErr(rxFrameErr), .rxOverrun(rxOverrun),
    .rxFull(rxFull), .rxStrobe(rxStrobe), .rxBreak(rxBreak)
  );

  always @(negedge clk) begin
    if (gapCnt >= tickGap - 1) begin sampleEn = 1'b1; gapCnt = 0; end
    else begin sampleEn = 1'b0; gapCnt = gapCnt + 1; end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (rxStrobe && prevStrobe) check(1'b0, "R11 strobe width", 2, 1);
      if (rxBreak) breakSeen++;
      if (rxStrobe) begin
        if (expQ.size() == 0) check(1'b0, "R3/R8 unexpected char", {21'd0, rxData, rxMp, rxParErr, rxFrameErr}, 0);
        else begin
          logic [10:0] e;
          e = expQ.pop_front();
          // R2 R5 R6 R7 R11 character content
          check({rxData, rxMp, rxParErr, rxFrameErr, rxOverrun, rxFull} == {e, 2'b01},
                "R2/R5/R6/R7/R11 char", {19'd0, rxData, rxMp, rxParErr, rxFrameErr, rxOverrun, rxFull},
                {19'd0, e, 2'b01});
        end
      end
      prevStrobe = rxStrobe;
    end
    readAck = (rxStrobe && autoRead) || manualAck;
  end

  function automatic int ratioN(input logic [1:0] r);
    case (r) 2'd0: return 1; 2'd1: return 16; 2'd2: return 32; default: return 64; endcase
  endfunction

  task automatic holdBit(input logic v);
    rxLine = v;
    repeat (ratioN(cfgRatio) * tickGap) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit parBad, input bit mpV,
                           input bit stopV, input bit expectChar);
    logic p;
    p = (^d) ^ cfgParityOdd ^ parBad;
    if (expectChar)
      expQ.push_back({d, cfgMpEn & mpV, cfgParityEn & parBad, ~stopV});
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(d[i]);
    if (cfgParityEn) holdBit(p);
    if (cfgMpEn) holdBit(mpV);
    holdBit(stopV);
    rxLine = 1'b1;
    repeat (3 * ratioN(cfgRatio) * tickGap + 8) @(negedge clk);
  endtask

  task automatic drained(input string req);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({rxFull, rxStrobe, rxBreak, rxOverrun, rxParErr, rxFrameErr, rxMp} == 7'd0,
          "R1 reset", {rxFull, rxStrobe, rxBreak, rxOverrun, rxParErr, rxFrameErr, rxMp}, 0);

    // R2 ratio 16, plain frames, LSB first
    cfgRatio = 2'd1;
    sendFrame(8'hA5, 0, 0, 1, 1);
    sendFrame(8'h01, 0, 0, 1, 1);
    sendFrame(8'hFF, 0, 0, 1, 1);
    // R2 sparse tick: one tick every 3 cycles
    tickGap = 3;
    sendFrame(8'h3C, 0, 0, 1, 1);
    tickGap = 1;
    drained("R2 ratio16 frames");

    // R5 even then odd parity at ratio 32
    cfgRatio = 2'd2; cfgParityEn = 1'b1; cfgParityOdd = 1'b0;
    sendFrame(8'h96, 0, 0, 1, 1);
    sendFrame(8'h96, 1, 0, 1, 1);
    cfgParityOdd = 1'b1;
    sendFrame(8'h07, 0, 0, 1, 1);
    sendFrame(8'h07, 1, 0, 1, 1);
    drained("R5 parity frames");

    // R6 marker bit with and without parity at ratio 64
    cfgRatio = 2'd3; cfgMpEn = 1'b1;
    sendFrame(8'h80, 0, 1, 1, 1);
    cfgParityEn = 1'b0;
    sendFrame(8'h00, 0, 1, 1, 1);
    sendFrame(8'h7E, 0, 0, 1, 1);
    drained("R6 marker frames");

    // R4 ratio 1
    cfgRatio = 2'd0; cfgMpEn = 1'b0;
    sendFrame(8'hC3, 0, 0, 1, 1);
    cfgMpEn = 1'b1;
    sendFrame(8'h5A, 0, 1, 1, 1);
    cfgMpEn = 1'b0;
    drained("R4 ratio1 frames");

    // R7 framing error
    cfgRatio = 2'd1;
    sendFrame(8'h5A, 0, 0, 0, 1);
    drained("R7 framing");

    // R8 break: all-zero frame, line low two more bits, then high
    breakSeen = 0;
    rxLine = 1'b0;
    repeat (12 * 16) @(negedge clk);
    rxLine = 1'b1;
    repeat (64) @(negedge clk);
    check(breakSeen == 1, "R8 break pulse", breakSeen, 1);
    drained("R8 no char on break");
    sendFrame(8'h42, 0, 0, 1, 1);
    drained("R8 resume after break");

    // R3 glitch shorter than half a bit
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (40) @(negedge clk);
    check(rxStrobe == 1'b0 && expQ.size() == 0, "R3 glitch rejected", rxStrobe, 0);
    sendFrame(8'h99, 0, 0, 1, 1);
    drained("R3 frame after glitch");

    // R9 overrun, R10 read ack
    autoRead = 1'b0;
    sendFrame(8'h11, 0, 0, 1, 1);
    sendFrame(8'h22, 0, 0, 1, 0);
    check(rxOverrun == 1'b1, "R9 overrun flag", rxOverrun, 1);
    check(rxData == 8'h11 && rxFull, "R9 held data kept", rxData, 8'h11);
    @(posedge clk); #1 manualAck = 1'b1;
    @(posedge clk); #1 manualAck = 1'b0;
    @(negedge clk); @(negedge clk);
    check(rxFull == 1'b0 && rxOverrun == 1'b0, "R10 ack clears", {rxFull, rxOverrun}, 0);
    autoRead = 1'b1;
    sendFrame(8'h33, 0, 0, 1, 1);
    drained("R10 receive after ack");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule